// File: doc/BRIEF.md
# Cascaded-Counter PWM Generator

This block produces a pulse-width modulated output from a counter built from two equal halves (two 8-bit halves by default, so a 16-bit period). The counter advances on an internal tick enable or, when selected, on falling edges of an external clock that is first brought into the system clock domain. One output flip-flop sets the waveform. When the block starts it loads a chosen initial level. It flips when the counter reaches the active duty value, and it flips back when the counter wraps from all ones to zero. The wrap also clears the counter and raises a one-cycle interrupt. The output pin always shows the complement of the flip-flop.

The duty value arrives as two beats on a valid/ready byte stream: the low half comes first, then the high half. The beats are assembled in a staging register, and only a completed pair is marked pending. A pending value moves into the active compare register at a start or at a wrap, never part-way through a period, so software can change the duty while the output runs. The stream applies no back-pressure: `wr_ready` is held high, and a beat is taken in every cycle in which `wr_valid` is high.

Top module: `pwm16_gen`

## Requirements
- R1: After reset `pwm_out` is 1 (flip-flop cleared to 0), `irq` is 0 and `wr_ready` is 1.
- R2: On the cycle after `run` rises, the counter is 0 and the flip-flop holds `init_lvl`, so `pwm_out` equals the complement of `init_lvl`.
- R3: With an active duty value D other than 0, `pwm_out` equals the complement of `init_lvl` for exactly D count steps of each period, which are counter values 0 to D-1. For the rest of the period it equals `init_lvl`.
- R4: A period lasts 2^(2*HALF_W) count steps. At the wrap the counter returns to 0 and the flip-flop returns to `init_lvl`.
- R5: `irq` is high for exactly one cycle at each wrap and at no other time.
- R6: `pwm_out` is always the logical complement of the output flip-flop.
- R7: A duty value of 0 never matches, so `pwm_out` stays at the complement of `init_lvl` for the whole period.
- R8: The first accepted beat after a completed pair is the low half and the second is the high half. A value becomes pending only on the high-half beat, and a lone low beat never changes the active duty value.
- R9: A pending value becomes active only at a start or at a wrap. A value written mid-period takes effect from the next period.
- R10: With `use_ext`=1 the counter advances once per falling edge of the synchronised `ext_clk`, and `tick` is ignored. Each input level must last at least 2 cycles. With `use_ext`=0 the counter advances on each cycle in which `tick` is high.
- R11: `wr_ready` is always 1, so a beat is accepted in every cycle with `wr_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Run enable; its rising edge starts a period |
| init_lvl | input | 1 | Level loaded into the output flip-flop at start |
| use_ext | input | 1 | 1: count external falling edges; 0: count tick |
| tick | input | 1 | Internal count enable |
| ext_clk | input | 1 | Asynchronous external count clock |
| wr_valid | input | 1 | Duty beat valid |
| wr_ready | output | 1 | Duty beat ready (always 1) |
| wr_data | input | HALF_W | Duty half, low half first, then high half |
| pwm_out | output | 1 | Complement of the output flip-flop |
| irq | output | 1 | One-cycle pulse at each counter wrap |

## Verification
The bench runs the generator with seeded random duty values and initial levels. It measures the on-time in each period between two interrupts, and a wrong match point or a wrong polarity shows up there as a count error. Directed cases add a duty of 0, which separates "no match" from an off-by-one compare. They also add a change written in the middle of a period and a lone low-half write, which show whether the transfer waits for the wrap and for a completed pair. A run on the external clock with `tick` held high separates edge counting from tick counting, because the period comes out four times longer.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  localparam int PWM_HALF_W = 8;
  typedef enum logic {SRC_TICK = 1'b0, SRC_EXT = 1'b1} clk_src_e;
endpackage

// File: rtl/pwm16_extsync.sv
module pwm16_extsync (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic fall
);
  logic s1, s2, s3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= ext_in; s2 <= s1; s3 <= s2;
    end
  end
  assign fall = s3 & ~s2;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R10
endmodule

// File: rtl/pwm16_dbuf.sv
module pwm16_dbuf #(
  parameter int HW = 8,
  localparam int CW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [HW-1:0] wr_data,
  input  logic          take,
  output logic [CW-1:0] staged,
  output logic          pend
);
  logic          hi_next;
  logic [HW-1:0] lo_hold;
  logic          hi_wr;

  assign hi_wr = wr_fire & hi_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_next <= 1'b0;
      lo_hold <= '0;
      staged  <= '0;
      pend    <= 1'b0;
    end else begin
      if (wr_fire) hi_next <= ~hi_next;
      if (wr_fire && !hi_next) lo_hold <= wr_data;
      if (hi_wr) staged <= {wr_data, lo_hold};
      if (hi_wr) pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end

  AST_PEND_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> pend); // R8
  AST_LOW_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(staged)); // R8
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take && !hi_wr |=> !pend); // R9
endmodule

// File: rtl/pwm16_core.sv
module pwm16_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          init_lvl,
  input  logic          step,
  input  logic [CW-1:0] staged,
  input  logic          pend,
  output logic          take,
  output logic          ff_q,
  output logic          irq
);
  logic [CW-1:0] cnt, active, nxt;
  logic          run_q, start, adv, wrap, hit;

  assign start = run & ~run_q;
  assign adv   = run & run_q & step;
  assign wrap  = &cnt;
  assign nxt   = wrap ? '0 : cnt + 1'b1;
  assign hit   = (nxt == active);
  assign take  = (start | (adv & wrap)) & pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt    <= '0;
      active <= '0;
      ff_q   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      run_q <= run;
      irq   <= adv & wrap;
      if (take) active <= staged;
      if (start) begin
        cnt  <= '0;
        ff_q <= init_lvl;
      end else if (adv) begin
        cnt <= nxt;
        if (hit ^ wrap) ff_q <= ~ff_q;
      end
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0) && (ff_q == $past(init_lvl))); // R2
  AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    adv && wrap && !start |=> cnt == '0); // R4
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt == '0); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !adv |=> $stable(cnt)); // R10
  AST_ACTIVE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(active)); // R9
endmodule

// File: rtl/pwm16_gen.sv
module pwm16_gen
  import pwm16_pkg::*;
#(
  parameter int HALF_W = PWM_HALF_W,
  localparam int CW = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              init_lvl,
  input  logic              use_ext,
  input  logic              tick,
  input  logic              ext_clk,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [HALF_W-1:0] wr_data,
  output logic              pwm_out,
  output logic              irq
);
  clk_src_e      src;
  logic          ext_fall, step, take, pend, ff_q;
  logic [CW-1:0] staged;

  assign src      = use_ext ? SRC_EXT : SRC_TICK;
  assign step     = (src == SRC_EXT) ? ext_fall : tick;
  assign wr_ready = 1'b1;

  pwm16_extsync u_sync (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_clk), .fall(ext_fall)
  );

  pwm16_dbuf #(.HW(HALF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_valid & wr_ready),
    .wr_data(wr_data), .take(take), .staged(staged), .pend(pend)
  );

  pwm16_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .init_lvl(init_lvl),
    .step(step), .staged(staged), .pend(pend), .take(take),
    .ff_q(ff_q), .irq(irq)
  );

  assign pwm_out = ~ff_q;

  AST_PIN_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out != ff_q); // R6
endmodule

// File: tb/pwm16_gen_tb.sv
module pwm16_gen_tb;
  localparam int HW = 4;
  localparam int P  = 1 << (2 * HW);

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, init_lvl = 1'b0, use_ext = 1'b0;
  logic tick = 1'b0, ext_clk = 1'b0, wr_valid = 1'b0, wr_ready, pwm_out, irq;
  logic [HW-1:0] wr_data = '0;
  bit   ext_en = 1'b0;
  int   ext_div = 0;
  int   total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  pwm16_gen #(.HALF_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .init_lvl(init_lvl), .use_ext(use_ext),
    .tick(tick), .ext_clk(ext_clk), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq)
  );

  always @(negedge clk) begin
    if (ext_en) begin
      ext_div = ext_div + 1;
      if (ext_div == 2) begin ext_clk = ~ext_clk; ext_div = 0; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int exp_on(int d, int scale);
    return (d == 0) ? P * scale : d * scale;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_duty(int d);
    wr_valid = 1'b1; wr_data = d[HW-1:0];
    @(negedge clk);
    wr_data = d[2*HW-1:HW];
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic start_run(logic il, int d);
    run = 1'b0;
    @(negedge clk); @(negedge clk);
    write_duty(d);
    init_lvl = il;
    run = 1'b1;
    @(negedge clk);
    check(pwm_out == ~il, "R2 start level", pwm_out, ~il);
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  // Starts at an irq sample, ends at the next irq sample.
  task automatic measure(logic il, int d, bit do_wr, bit lo_only, int nd, string tag);
    int on = 0;
    int extra = 0;
    for (int i = 0; i < P; i++) begin
      if (pwm_out == ~il) on++;
      if (i > 0 && irq) extra++;
      if (do_wr) begin
        if (i == 10) begin wr_valid = 1'b1; wr_data = nd[HW-1:0]; end
        else if (i == 11) begin
          if (lo_only) wr_valid = 1'b0; else wr_data = nd[2*HW-1:HW];
        end
        else if (i == 12) wr_valid = 1'b0;
      end
      @(negedge clk);
    end
    check(on == exp_on(d, 1), tag, on, exp_on(d, 1));
    check(extra == 0 && irq == 1'b1, "R5 irq once per period", extra, 0);
  endtask

  initial begin
    int seed_dummy;
    int d, d2;
    logic il;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pwm_out == 1'b1, "R1 pwm after reset", pwm_out, 1);
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    check(wr_ready == 1'b1, "R11 ready", wr_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    tick = 1'b1;

    // R3/R4/R6 random duty values and levels
    for (int k = 0; k < 8; k++) begin
      d  = int'($urandom_range(1, P - 1));
      il = logic'($urandom_range(0, 1));
      start_run(il, d);
      wait_irq();
      measure(il, d, 1'b0, 1'b0, 0, "R3 R6 on-time random");
      measure(il, d, 1'b0, 1'b0, 0, "R4 next period same");
    end

    // Directed edges: duty 1, duty P-1, duty 0 (R7)
    start_run(1'b0, 1);
    wait_irq();
    measure(1'b0, 1, 1'b0, 1'b0, 0, "R3 duty 1");
    start_run(1'b1, P - 1);
    wait_irq();
    measure(1'b1, P - 1, 1'b0, 1'b0, 0, "R3 duty max");
    start_run(1'b0, 0);
    wait_irq();
    measure(1'b0, 0, 1'b0, 1'b0, 0, "R7 duty zero");

    // R9 mid-period change applies next period
    d = 40; d2 = 200;
    start_run(1'b1, d);
    wait_irq();
    measure(1'b1, d, 1'b1, 1'b0, d2, "R9 old duty kept this period");
    measure(1'b1, d2, 1'b0, 1'b0, 0, "R9 new duty next period");

    // R8 lone low beat is not applied (pairing restored afterwards)
    d = 100;
    start_run(1'b0, d);
    wait_irq();
    measure(1'b0, d, 1'b1, 1'b1, 9, "R8 lone low ignored");
    measure(1'b0, d, 1'b0, 1'b0, 0, "R8 lone low ignored next");
    wr_valid = 1'b1; wr_data = '0;
    @(negedge clk);
    wr_valid = 1'b0;

    // R10 external clock, tick held high and ignored
    begin
      int gap = 0;
      int on = 0;
      d = 30;
      use_ext = 1'b1;
      ext_en = 1'b1;
      start_run(1'b1, d);
      wait_irq();
      @(negedge clk);
      gap = 1;
      if (pwm_out == 1'b0) on++;
      while (!irq && gap < 3000) begin
        if (pwm_out == 1'b0) on++;
        @(negedge clk);
        gap++;
      end
      check(gap == 4 * P, "R10 external period", gap, 4 * P);
      check(on == exp_on(d, 4), "R10 external on-time", on, exp_on(d, 4));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule